// File: doc/BRIEF.md
# Rotor-Frame Vector Transformation Engine

This block converts motor quantities between the stator frame and the rotor frame. A host loads 12-bit twos-complement operands into three input slots and then writes a 12-bit rotor angle. The slot it writes selects the direction. A reverse run reduces three phase currents to an orthogonal pair, then rotates that pair by the angle to give the flux and torque components. A forward run rotates a direct/quadrature pair by the angle, then expands the result into three phase values.

A single multiplier is shared across the whole computation, stepped by a sequencer. Sine and cosine come from a quarter-wave table with quadrant folding. Every run takes the same fixed number of clocks, and only one run is active at a time. Completion sets a status flag that software can clear, and it can raise an interrupt line.

In the reverse direction, a control bit chooses where the first phase comes from. Either the host supplies it, or the engine derives it from the other two phases, as in drives that measure only two currents.

Top module: `vt_engine`

## Requirements
- R1: After reset, every readable location (results at read addresses 0 to 2, angle at 3, control at 4, status at 5) reads zero and `irq` is low.
- R2: A write to address 3 (reverse) or address 5 (forward) while idle starts a run. The angle is stored, and status bit 2 (busy) reads 1 from the next cycle.
- R3: Results, status bit 1 (done) and `irq` change exactly 37 clock edges after the edge that accepted the start write. Busy stays 1 up to that edge and clears at it.
- R4: Reverse, with alpha = phase A and beta = floor((B − C)·2365/4096): result 0 = floor((alpha·cos + beta·sin)/4096), result 1 = floor((beta·cos − alpha·sin)/4096), and result 2 = 0.
- R5: Control bit 10 = 0 (the reset value) selects derived mode. In this mode phase A is replaced by sat(−(B + C)) and the written A value is ignored. Control bit 10 = 1 uses the written A.
- R6: Sine and cosine equal round(4096·sin) and round(4096·cos) of 2π·k/64, where k is angle bits 11:6. Angle bits 5:0 have no effect.
- R7: Forward, with inputs d = slot 0 and q = slot 1: alpha = sat(floor((d·cos − q·sin)/4096)), beta = sat(floor((d·sin + q·cos)/4096)), and t = floor(beta·3547/4096). Result 0 = alpha, result 1 = sat(t − floor(alpha/2)), and result 2 = sat(−t − floor(alpha/2)).
- R8: Every result, and the derived phase, saturates to the range −2048 to 2047 instead of wrapping.
- R9: A start write to address 3 or 5 while busy is ignored. The stored angle, the result and the completion time are unaffected.
- R10: `irq` equals done AND control bit 6. Done clears when a new run starts, and when address 5 is read with `rdEn` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 to 2 input slots, 3 reverse angle, 4 control, 5 forward angle |
| wrData | input | 12 | Write data |
| rdEn | input | 1 | Read strobe; a read of status with this high clears done |
| rdAddr | input | 3 | Read address |
| rdData | output | 12 | Combinational read data |
| irq | output | 1 | Completion interrupt |

## Verification
Busy is due one edge after the accepted start write. Done, `irq` and the three results are all due together, 37 edges after that start. The bench stamps every queued expectation with its due cycle. A monitor samples at the falling edge before that cycle, where busy must still be set and done must still be clear. It samples again at the falling edge after it, where every result must be present. A result that arrives one cycle early or one cycle late is therefore caught. The status-clear and the ignored-start checks are sampled one cycle after their stimulus.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int DW = 12;          // register width
  localparam int WW = 14;          // working operand width
  localparam int AW = 3;           // register address width
  localparam int TAB_BITS = 6;     // angle bits used for lookup

  localparam logic [AW-1:0] AD_IN0  = 3'd0;
  localparam logic [AW-1:0] AD_IN1  = 3'd1;
  localparam logic [AW-1:0] AD_IN2  = 3'd2;
  localparam logic [AW-1:0] AD_REV  = 3'd3;
  localparam logic [AW-1:0] AD_CTRL = 3'd4;
  localparam logic [AW-1:0] AD_FWD  = 3'd5;
  localparam logic [AW-1:0] AD_STAT = 3'd5;

  localparam int BIT_THREE = 10;
  localparam int BIT_IEN   = 6;

  typedef enum logic [3:0] {
    OP_IDLE, OP_PREP, OP_SCALE, OP_MUL, OP_MACP, OP_MACN,
    OP_HOLD1, OP_HOLD2, OP_SCALE2, OP_COMMIT
  } vtOp_e;
  typedef enum logic [1:0] {X_A, X_B, X_H2} vtX_e;
  typedef enum logic [1:0] {Y_COS, Y_SIN, Y_KCLK, Y_KINV} vtY_e;

  typedef struct packed {
    logic  start;
    logic  fwd;
    vtOp_e op;
    vtX_e  xSel;
    vtY_e  ySel;
  } vtStrobe_t;

  function automatic logic signed [DW-1:0] sat12(input logic signed [29:0] v);
    if (v > 30'sd2047) return 12'sd2047;
    else if (v < -30'sd2048) return -12'sd2048;
    else return v[DW-1:0];
  endfunction
endpackage

// File: rtl/vt_ctrl.sv
module vt_ctrl
  import vt_pkg::*;
#(
  parameter int LATENCY = 37
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic [DW-1:0]        wrData,
  input  logic                 rdEn,
  input  logic [AW-1:0]        rdAddr,
  output logic signed [DW-1:0] in0,
  output logic signed [DW-1:0] in1,
  output logic signed [DW-1:0] in2,
  output logic [DW-1:0]        ctrlQ,
  output logic [DW-1:0]        angleQ,
  output logic                 busy,
  output logic                 doneFlag,
  output vtStrobe_t            stb
);
  localparam int CW = $clog2(LATENCY);

  logic [CW-1:0] cnt;
  logic          fwdQ;
  logic          angleWr, startOk, statusClr, lastStep;

  assign angleWr   = wrEn && (wrAddr == AD_REV || wrAddr == AD_FWD);
  assign startOk   = angleWr && !busy;
  assign statusClr = rdEn && (rdAddr == AD_STAT);
  assign lastStep  = busy && (cnt == CW'(LATENCY - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      in0 <= '0; in1 <= '0; in2 <= '0; ctrlQ <= '0; angleQ <= '0;
      busy <= 1'b0; doneFlag <= 1'b0; cnt <= '0; fwdQ <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          AD_IN0:  in0 <= wrData;
          AD_IN1:  in1 <= wrData;
          AD_IN2:  in2 <= wrData;
          AD_CTRL: ctrlQ <= wrData;
          default: ;
        endcase
      end
      if (startOk) begin
        busy   <= 1'b1;
        cnt    <= '0;
        fwdQ   <= (wrAddr == AD_FWD);
        angleQ <= wrData;
      end else if (lastStep) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (startOk)        doneFlag <= 1'b0;
      else if (lastStep)  doneFlag <= 1'b1;
      else if (statusClr) doneFlag <= 1'b0;
    end
  end

  always_comb begin
    stb       = '0;
    stb.start = startOk;
    stb.fwd   = fwdQ;
    if (lastStep) begin
      stb.op = OP_COMMIT;
    end else if (busy) begin
      case (cnt)
        CW'(0): stb.op = OP_PREP;
        CW'(1): if (!fwdQ) begin stb.op = OP_SCALE; stb.xSel = X_B; stb.ySel = Y_KCLK; end
        CW'(2): begin stb.op = OP_MUL; stb.xSel = X_A; stb.ySel = Y_COS; end
        CW'(3): begin stb.op = fwdQ ? OP_MACN : OP_MACP; stb.xSel = X_B; stb.ySel = Y_SIN; end
        CW'(4): stb.op = OP_HOLD1;
        CW'(5): begin
          stb.op   = OP_MUL;
          stb.xSel = fwdQ ? X_A : X_B;
          stb.ySel = fwdQ ? Y_SIN : Y_COS;
        end
        CW'(6): begin
          stb.op   = fwdQ ? OP_MACP : OP_MACN;
          stb.xSel = fwdQ ? X_B : X_A;
          stb.ySel = fwdQ ? Y_COS : Y_SIN;
        end
        CW'(7): stb.op = OP_HOLD2;
        CW'(8): if (fwdQ) begin stb.op = OP_SCALE2; stb.xSel = X_H2; stb.ySel = Y_KINV; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vt_datapath.sv
module vt_datapath
  import vt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  vtStrobe_t             stb,
  input  logic signed [DW-1:0]  in0,
  input  logic signed [DW-1:0]  in1,
  input  logic signed [DW-1:0]  in2,
  input  logic                  threeIn,
  input  logic [TAB_BITS-1:0]   angleTop,
  output logic signed [DW-1:0]  out0,
  output logic signed [DW-1:0]  out1,
  output logic signed [DW-1:0]  out2
);
  localparam logic signed [WW-1:0] K_CLARKE = 14'sd2365;  // 4096/sqrt(3)
  localparam logic signed [WW-1:0] K_HALF3  = 14'sd3547;  // 4096*sqrt(3)/2

  logic [TAB_BITS-1:0]     angC;
  logic signed [WW-1:0]    wA, wB, h3, magS, magC, sinV, cosV, mulX, mulY;
  logic signed [DW-1:0]    h1, h2, half;
  logic signed [2*WW-1:0]  prod;
  logic signed [2*WW:0]    acc;

  function automatic logic signed [WW-1:0] quarter(input logic [4:0] k);
    case (k)
      5'd0:  return 14'sd0;    5'd1:  return 14'sd401;  5'd2:  return 14'sd799;
      5'd3:  return 14'sd1189; 5'd4:  return 14'sd1567; 5'd5:  return 14'sd1931;
      5'd6:  return 14'sd2276; 5'd7:  return 14'sd2598; 5'd8:  return 14'sd2896;
      5'd9:  return 14'sd3166; 5'd10: return 14'sd3406; 5'd11: return 14'sd3612;
      5'd12: return 14'sd3784; 5'd13: return 14'sd3920; 5'd14: return 14'sd4017;
      5'd15: return 14'sd4076; 5'd16: return 14'sd4096;
      default: return 14'sd0;
    endcase
  endfunction

  assign magS = quarter({1'b0, angC[3:0]});
  assign magC = quarter(5'd16 - {1'b0, angC[3:0]});

  always_comb begin
    case (angC[5:4])
      2'd0:    begin sinV = magS;  cosV = magC;  end
      2'd1:    begin sinV = magC;  cosV = -magS; end
      2'd2:    begin sinV = -magS; cosV = -magC; end
      default: begin sinV = -magC; cosV = magS;  end
    endcase
  end

  always_comb begin
    case (stb.xSel)
      X_A:     mulX = wA;
      X_B:     mulX = wB;
      default: mulX = WW'(h2);
    endcase
    case (stb.ySel)
      Y_COS:   mulY = cosV;
      Y_SIN:   mulY = sinV;
      Y_KCLK:  mulY = K_CLARKE;
      default: mulY = K_HALF3;
    endcase
  end

  assign prod = mulX * mulY;
  assign half = h1 >>> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      angC <= '0; wA <= '0; wB <= '0; h1 <= '0; h2 <= '0; h3 <= '0; acc <= '0;
      out0 <= '0; out1 <= '0; out2 <= '0;
    end else begin
      if (stb.start) angC <= angleTop;
      case (stb.op)
        OP_PREP: begin
          if (stb.fwd) begin
            wA <= WW'(in0);
            wB <= WW'(in1);
          end else begin
            wA <= threeIn ? WW'(in0) : WW'(sat12(-(30'(in1) + 30'(in2))));
            wB <= WW'(in1) - WW'(in2);
          end
        end
        OP_SCALE:  wB  <= WW'(prod >>> 12);
        OP_MUL:    acc <= (2*WW+1)'(prod);
        OP_MACP:   acc <= acc + (2*WW+1)'(prod);
        OP_MACN:   acc <= acc - (2*WW+1)'(prod);
        OP_HOLD1:  h1  <= sat12(30'(acc >>> 12));
        OP_HOLD2:  h2  <= sat12(30'(acc >>> 12));
        OP_SCALE2: h3  <= WW'(prod >>> 12);
        OP_COMMIT: begin
          out0 <= h1;
          if (stb.fwd) begin
            out1 <= sat12(30'(h3) - 30'(half));
            out2 <= sat12(-30'(h3) - 30'(half));
          end else begin
            out1 <= h2;
            out2 <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vt_engine.sv
module vt_engine
  import vt_pkg::*;
#(
  parameter int LATENCY = 37
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [11:0]   wrData,
  input  logic          rdEn,
  input  logic [2:0]    rdAddr,
  output logic [11:0]   rdData,
  output logic          irq
);
  logic signed [DW-1:0] in0, in1, in2, out0, out1, out2;
  logic [DW-1:0]        ctrlQ, angleQ;
  logic                 busy, doneFlag;
  vtStrobe_t            stb;

  vt_ctrl #(.LATENCY(LATENCY)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .in0(in0), .in1(in1), .in2(in2),
    .ctrlQ(ctrlQ), .angleQ(angleQ), .busy(busy), .doneFlag(doneFlag), .stb(stb)
  );

  vt_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .in0(in0), .in1(in1), .in2(in2),
    .threeIn(ctrlQ[BIT_THREE]), .angleTop(wrData[DW-1:DW-TAB_BITS]),
    .out0(out0), .out1(out1), .out2(out2)
  );

  always_comb begin
    case (rdAddr)
      3'd0:    rdData = out0;
      3'd1:    rdData = out1;
      3'd2:    rdData = out2;
      3'd3:    rdData = angleQ;
      3'd4:    rdData = ctrlQ;
      3'd5:    rdData = {9'b0, busy, doneFlag, 1'b0};
      default: rdData = '0;
    endcase
  end

  assign irq = doneFlag & ctrlQ[BIT_IEN];
endmodule

// File: rtl/vt_engine_chk.sv
module vt_engine_chk #(
  parameter int LATENCY = 37
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [2:0]  wrAddr,
  input logic        rdEn,
  input logic [2:0]  rdAddr,
  input logic        irq,
  input logic        busy,
  input logic        doneFlag,
  input logic [11:0] angleQ
);
  logic startReq;
  int   chkCnt;

  assign startReq = wrEn && (wrAddr == 3'd3 || wrAddr == 3'd5);

  always_ff @(posedge clk) begin
    if (!rstN)                    chkCnt <= 0;
    else if (startReq && !busy)   chkCnt <= 0;
    else if (busy)                chkCnt <= chkCnt + 1;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  // R3
  latency_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && chkCnt < LATENCY - 1) |=> (busy && !doneFlag));

  // R3
  latency_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && chkCnt == LATENCY - 1) |=> (!busy && doneFlag));

  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && busy) |=> $stable(angleQ));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 3'd5 && !busy && !startReq) |=> !doneFlag);
endmodule

bind vt_engine vt_engine_chk #(.LATENCY(LATENCY)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn),
  .rdAddr(rdAddr), .irq(irq), .busy(busy), .doneFlag(doneFlag), .angleQ(angleQ)
);

// File: tb/vt_engine_tb_top.sv
module vt_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  dAddr = '0;
  logic [2:0]  mAddr = '0;
  logic        monBusy = 1'b0;
  logic [2:0]  rdAddr;
  logic [11:0] rdData;
  logic        irq;
  int          cyc = 0;
  int          nChk = 0;
  int          nFail = 0;

  typedef struct { int o0; int o1; int o2; int due; bit ien; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign rdAddr = monBusy ? mAddr : dAddr;

  vt_engine dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 2047) ? 2047 : ((v < -2048) ? -2048 : v);
  endfunction

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v * 4096.0 + 0.5) : -$rtoi(-v * 4096.0 + 0.5);
  endfunction

  // expected values straight from R4 to R8
  function automatic void model(input bit fwd, input bit three, input int i0, input int i1,
                                input int i2, input int ang, output int o0, output int o1,
                                output int o2);
    real th = 2.0 * 3.14159265358979323846 * real'(ang >> 6) / 64.0;
    int s = rnd($sin(th));
    int c = rnd($cos(th));
    int a, b, t, h;
    if (!fwd) begin
      a  = three ? i0 : sat(-(i1 + i2));
      b  = ((i1 - i2) * 2365) >>> 12;
      o0 = sat((a * c + b * s) >>> 12);
      o1 = sat((b * c - a * s) >>> 12);
      o2 = 0;
    end else begin
      a  = sat((i0 * c - i1 * s) >>> 12);
      b  = sat((i0 * s + i1 * c) >>> 12);
      t  = (b * 3547) >>> 12;
      h  = a >>> 1;
      o0 = a;
      o1 = sat(t - h);
      o2 = sat(-t - h);
    end
  endfunction

  task automatic wrReg(input logic [2:0] a, input int d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = 12'(d);
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic launch(input bit fwd, input bit three, input bit ien, input int i0,
                        input int i1, input int i2, input int ang, input string tag);
    exp_t e;
    wrReg(3'd4, (int'(three) << 10) | (int'(ien) << 6));
    wrReg(3'd0, i0);
    wrReg(3'd1, i1);
    wrReg(3'd2, i2);
    model(fwd, three, i0, i1, i2, ang, e.o0, e.o1, e.o2);
    e.ien = ien;
    e.tag = tag;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = fwd ? 3'd5 : 3'd3; wrData = 12'(ang);
    e.due = cyc + 38;
    q.push_back(e);
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitDone();
    wait (q.size() == 0 && !monBusy);
    @(negedge clk);
  endtask

  // monitor: samples each queued item at due-1 and due (R3)
  initial begin
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q[0];
      while (cyc < e.due - 1) @(negedge clk);
      monBusy = 1'b1; mAddr = 3'd5; #1;
      check({e.tag, " R3 busy one cycle before due"}, int'(rdData[2]), 1);
      check({e.tag, " R3 done one cycle before due"}, int'(rdData[1]), 0);
      check({e.tag, " R3 irq one cycle before due"}, int'(irq), 0);
      @(negedge clk); #1;
      check({e.tag, " R3 done at due"}, int'(rdData[1]), 1);
      check({e.tag, " R3 busy cleared at due"}, int'(rdData[2]), 0);
      check({e.tag, " R10 irq follows enable"}, int'(irq), int'(e.ien));
      mAddr = 3'd0; #1; check({e.tag, " result0"}, int'($signed(rdData)), e.o0);
      mAddr = 3'd1; #1; check({e.tag, " result1"}, int'($signed(rdData)), e.o1);
      mAddr = 3'd2; #1; check({e.tag, " result2"}, int'($signed(rdData)), e.o2);
      void'(q.pop_front());
      monBusy = 1'b0;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL R3 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      dAddr = 3'(a); #1;
      check("R1 reset readback", int'(rdData), 0);
    end
    check("R1 reset irq", int'(irq), 0);

    launch(1'b0, 1'b1, 1'b1, 1000, -300, -700, 0, "R4 reverse 0deg");
    waitDone();
    launch(1'b0, 1'b0, 1'b1, 777, 500, 200, 1024, "R5 derived phase 90deg");
    waitDone();
    launch(1'b0, 1'b1, 1'b1, 2047, 2047, -2048, 512, "R8 reverse 45deg saturate");
    waitDone();
    launch(1'b0, 1'b0, 1'b1, 0, -2048, -2048, 3000, "R8 R5 derived saturate");
    waitDone();
    launch(1'b0, 1'b1, 1'b1, 300, -400, 100, 1000, "R6 angle low bits dropped");
    waitDone();
    launch(1'b1, 1'b0, 1'b1, 600, -400, 0, 0, "R7 forward 0deg");
    waitDone();
    launch(1'b1, 1'b0, 1'b1, -1200, 900, 0, 2300, "R7 forward 202deg");
    waitDone();
    launch(1'b1, 1'b0, 1'b1, 2047, 2047, 0, 512, "R8 forward 45deg saturate");
    waitDone();
    launch(1'b1, 1'b1, 1'b1, -2048, -2048, 5, 3500, "R7 forward 307deg");
    waitDone();

    // R10: status read with rdEn clears done and irq
    @(negedge clk); dAddr = 3'd5; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; #1;
    check("R10 done cleared by status read", int'(rdData[1]), 0);
    check("R10 irq cleared by status read", int'(irq), 0);

    // R9 and R2: start requests while busy are ignored
    launch(1'b0, 1'b1, 1'b1, 400, -100, 250, 2048, "R9 reverse ignores busy start");
    dAddr = 3'd5; #1;
    check("R2 busy after start", int'(rdData[2]), 1);
    repeat (3) @(negedge clk);
    wrReg(3'd3, 100);
    wrReg(3'd5, 1500);
    dAddr = 3'd3; #1;
    check("R9 angle unchanged by busy start", int'(rdData), 2048);
    waitDone();

    // R10: interrupt disabled, done still visible
    launch(1'b1, 1'b0, 1'b0, 800, 300, 0, 700, "R10 forward irq disabled");
    waitDone();
    dAddr = 3'd5; #1;
    check("R10 done set with irq disabled", int'(rdData[1]), 1);
    check("R10 irq stays low when disabled", int'(irq), 0);

    summary();
    $finish;
  end
endmodule